// File: doc/BRIEF.md
# Burst Packet Transmit Framer

This block sits between a slow host and a fast serial line. While the host holds its enable input high, it presents one bit per rising edge of a host bit clock, and the framer stores these bits (address first, then payload) in an internal buffer of up to 256 bits. When the host drops enable, the framer sends the packet on its own. It sends an 8-bit alternating preamble whose phase follows the first stored bit. It then sends the stored bits in the order they arrived. When the CRC is enabled, an 8- or 16-bit CRC follows, computed on the fly over the stored bits as they leave.

A one-cycle tick input sets the line rate: each tick during a burst moves exactly one bit onto the line, and a strobe marks each new line bit. Busy is high for the whole burst, and the framer returns to idle afterwards. Bits beyond the room left after the CRC field are dropped, and an overflow flag is raised. The CRC configuration comes from two parallel inputs and is captured when the burst starts.

Top module: `burst_tx_framer`

## Requirements
- R1: After reset `busy_o`, `ovf_o`, `line_stb_o` and `tx_o` are all 0.
- R2: While `en_i` is high and no burst is running, each rising edge of `hclk_i` stores `hdat_i` as the next packet bit. Stored bits are sent in arrival order, and a full buffer of 256 bits is sent completely when the CRC is off.
- R3: A falling `en_i` after at least one stored bit starts a burst: `busy_o` is high from the next cycle until the tick that sends the last bit. A falling `en_i` with no stored bits starts nothing.
- R4: The burst opens with 8 preamble bits. The pattern is 0,1,0,1,0,1,0,1 when the first stored bit is 0 and 1,0,1,0,1,0,1,0 when it is 1, leftmost bit first on the line.
- R5: The line carries the preamble, then the stored bits in arrival order, then the CRC bits (most significant first), and nothing else.
- R6: Each `tick_i` seen during a burst gives exactly one `line_stb_o` pulse in the following cycle, with the line bit on `tx_o`. `line_stb_o` never pulses without a tick in the cycle before.
- R7: With `crc_en_i`=1 and `crc_long_i`=1, a 16-bit CRC follows the data. It uses polynomial 0x1021 and start value 0xFFFF, with the data fed most significant bit first and no final inversion.
- R8: With `crc_en_i`=1 and `crc_long_i`=0, an 8-bit CRC follows the data. It uses polynomial 0x07 and start value 0xFF, with the same bit order. With `crc_en_i`=0, no CRC is sent.
- R9: The buffer holds 256 minus the CRC length bits (256, 248 or 240). Further host edges are dropped and set `ovf_o`, which is cleared when the next load begins.
- R10: Host clock edges during a burst store nothing and do not change the packet length or content.
- R11: `crc_en_i` and `crc_long_i` are captured at the falling edge of `en_i`; changing them during the burst has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Host enable: high to load, falling edge starts the burst |
| hclk_i | input | 1 | Host bit clock, synchronous to clk, rising edge stores a bit |
| hdat_i | input | 1 | Host data bit |
| crc_en_i | input | 1 | 1 = append CRC |
| crc_long_i | input | 1 | 1 = 16-bit CRC, 0 = 8-bit CRC |
| tick_i | input | 1 | Line-rate tick, one bit per tick |
| tx_o | output | 1 | Serial line bit |
| line_stb_o | output | 1 | One-cycle pulse marking a new bit on tx_o |
| busy_o | output | 1 | Burst in progress |
| ovf_o | output | 1 | Host loaded more bits than the buffer allows |

## Verification
The bench aims at the preamble phase for both values of the first bit. A framer with a fixed preamble would show a wrong leading bit for one of them. It also checks a known 72-bit message whose CRC-16 is 0x29B1, so a wrong start value or bit order shows in the last 16 bits. Other cases are an empty load, which must not start a burst, and a load three bits past the 240-bit limit, where a framer that kept writing would send a longer packet or fail to set the flag. The bench also toggles the host clock during a burst and flips the CRC configuration right after the start, so a framer that still listens to either would change the packet length.

// File: rtl/btf_pkg.sv
package btf_pkg;

    localparam int          PRE_LEN    = 8;
    localparam logic [15:0] CRC16_POLY = 16'h1021;
    localparam logic [7:0]  CRC8_POLY  = 8'h07;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_PRE  = 3'd2,
        ST_BODY = 3'd3,
        ST_CRC  = 3'd4
    } btf_state_e;

    // Number of CRC bits appended for a configuration
    function automatic logic [4:0] crc_len(input logic en, input logic wide);
        if (!en)
            return 5'd0;
        return wide ? 5'd16 : 5'd8;
    endfunction

    // One serial CRC update, MSB-first feed; the 8-bit form uses the low byte
    function automatic logic [15:0] crc_bit_step(input logic [15:0] c,
                                                 input logic b,
                                                 input logic wide);
        logic [15:0] r;
        logic        fb;
        r = c;
        if (wide) begin
            fb = b ^ c[15];
            r  = {c[14:0], 1'b0} ^ (fb ? CRC16_POLY : 16'h0000);
        end else begin
            fb      = b ^ c[7];
            r[7:0]  = {c[6:0], 1'b0} ^ (fb ? CRC8_POLY : 8'h00);
        end
        return r;
    endfunction

endpackage

// File: rtl/btf_bitstore.sv
module btf_bitstore #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] waddr_i,
    input  logic          wdat_i,
    input  logic [AW-1:0] raddr_i,
    output logic          rdat_o,
    output logic          head_o
);

    logic [DEPTH-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_i)
            mem_d[waddr_i] = wdat_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mem_q <= '0;
        else
            mem_q <= mem_d;
    end

    assign rdat_o = mem_q[raddr_i];
    assign head_o = mem_q[0];

    // R2
    stored_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> mem_q[$past(waddr_i)] == $past(wdat_i));

endmodule

// File: rtl/btf_crc.sv
module btf_crc (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic step_i,
    input  logic bit_i,
    input  logic shift_i,
    input  logic wide_i,
    output logic msb_o
);
    import btf_pkg::*;

    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (init_i)
            crc_d = 16'hFFFF;
        else if (step_i)
            crc_d = crc_bit_step(crc_q, bit_i, wide_i);
        else if (shift_i)
            crc_d = {crc_q[14:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= 16'hFFFF;
        else
            crc_q <= crc_d;
    end

    assign msb_o = wide_i ? crc_q[15] : crc_q[7];

    // R7
    crc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> crc_q == 16'hFFFF);

    // R8
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !step_i && !shift_i) |=> $stable(crc_q));

endmodule

// File: rtl/burst_tx_framer.sv
module burst_tx_framer #(
    parameter int  MAX_BITS = 256,
    localparam int CNT_W    = $clog2(MAX_BITS + 1),
    localparam int AW       = $clog2(MAX_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic hclk_i,
    input  logic hdat_i,
    input  logic crc_en_i,
    input  logic crc_long_i,
    input  logic tick_i,
    output logic tx_o,
    output logic line_stb_o,
    output logic busy_o,
    output logic ovf_o
);
    import btf_pkg::*;

    typedef struct packed {
        btf_state_e       st;
        logic             en_q;
        logic             hck_q;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] ridx;
        logic             ovf;
        logic             c_en;
        logic             c_long;
        logic             tx;
        logic             stb;
    } ctl_t;

    ctl_t             d, q;
    logic             hedge;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] crc_last;
    logic             wr_en;
    logic             crc_init, crc_step, crc_shift;
    logic             body_bit, head_bit, crc_bit;

    always_comb begin
        d         = q;
        d.stb     = 1'b0;
        d.en_q    = en_i;
        d.hck_q   = hclk_i;
        wr_en     = 1'b0;
        crc_init  = 1'b0;
        crc_step  = 1'b0;
        crc_shift = 1'b0;
        hedge     = hclk_i && !q.hck_q;
        limit     = CNT_W'(MAX_BITS) - CNT_W'(crc_len(crc_en_i, crc_long_i));
        crc_last  = CNT_W'(crc_len(q.c_en, q.c_long)) - CNT_W'(1);

        unique case (q.st)
            ST_IDLE: begin
                if (en_i) begin
                    d.st   = ST_LOAD;
                    d.wcnt = '0;
                    d.ovf  = 1'b0;
                end
            end
            ST_LOAD: begin
                if (!en_i) begin
                    if (q.wcnt == '0) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.st     = ST_PRE;
                        d.ridx   = '0;
                        d.c_en   = crc_en_i;
                        d.c_long = crc_long_i;
                        crc_init = 1'b1;
                    end
                end else if (hedge) begin
                    if (q.wcnt < limit) begin
                        wr_en  = 1'b1;
                        d.wcnt = q.wcnt + CNT_W'(1);
                    end else begin
                        d.ovf = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (tick_i) begin
                    d.tx  = head_bit ^ q.ridx[0];
                    d.stb = 1'b1;
                    if (q.ridx == CNT_W'(PRE_LEN - 1)) begin
                        d.st   = ST_BODY;
                        d.ridx = '0;
                    end else begin
                        d.ridx = q.ridx + CNT_W'(1);
                    end
                end
            end
            ST_BODY: begin
                if (tick_i) begin
                    d.tx     = body_bit;
                    d.stb    = 1'b1;
                    crc_step = 1'b1;
                    if (q.ridx == q.wcnt - CNT_W'(1)) begin
                        d.ridx = '0;
                        d.st   = q.c_en ? ST_CRC : ST_IDLE;
                    end else begin
                        d.ridx = q.ridx + CNT_W'(1);
                    end
                end
            end
            ST_CRC: begin
                if (tick_i) begin
                    d.tx      = crc_bit;
                    d.stb     = 1'b1;
                    crc_shift = 1'b1;
                    if (q.ridx == crc_last) begin
                        d.st   = ST_IDLE;
                        d.ridx = '0;
                    end else begin
                        d.ridx = q.ridx + CNT_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    btf_bitstore #(.DEPTH(MAX_BITS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en),
        .waddr_i (q.wcnt[AW-1:0]),
        .wdat_i  (hdat_i),
        .raddr_i (q.ridx[AW-1:0]),
        .rdat_o  (body_bit),
        .head_o  (head_bit)
    );

    btf_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (crc_init),
        .step_i  (crc_step),
        .bit_i   (body_bit),
        .shift_i (crc_shift),
        .wide_i  (q.c_long),
        .msb_o   (crc_bit)
    );

    assign tx_o       = q.tx;
    assign line_stb_o = q.stb;
    assign busy_o     = (q.st == ST_PRE) || (q.st == ST_BODY) || (q.st == ST_CRC);
    assign ovf_o      = q.ovf;

    // R3
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOAD && !en_i && q.wcnt != '0) |=> busy_o);

    // R6
    stb_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_stb_o |-> $past(tick_i));

    // R6
    tick_gives_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && tick_i) |=> line_stb_o);

    // R10
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(q.wcnt));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wcnt <= CNT_W'(MAX_BITS));

    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && q.st != ST_IDLE) |=> ovf_o);

endmodule

// File: tb/burst_tx_framer_bench.sv
`timescale 1ns/1ps
module burst_tx_framer_bench;

    localparam int MAXB = 256;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b0, hck = 1'b0, hdat = 1'b0;
    logic cen = 1'b0, clong = 1'b0, tick = 1'b0;
    logic tx, stb, busy, ovf;

    int   nchk = 0, nfail = 0;
    bit   data [0:299];
    bit   expb [0:349];
    bit   got  [0:399];
    int   nexp = 0, ngot = 0, stray = 0, tcnt = 0, cyc = 0;
    bit   tick_seen = 1'b0;

    always #2.5 clk = ~clk;

    burst_tx_framer u_burst_tx_framer (
        .clk(clk), .rst_n(rst_n), .en_i(en), .hclk_i(hck), .hdat_i(hdat),
        .crc_en_i(cen), .crc_long_i(clong), .tick_i(tick),
        .tx_o(tx), .line_stb_o(stb), .busy_o(busy), .ovf_o(ovf)
    );

    always @(negedge clk) begin
        tcnt = (tcnt == 2) ? 0 : tcnt + 1;
        tick = (tcnt == 0);
    end

    always @(posedge clk) tick_seen = tick;

    always @(negedge clk) begin
        if (stb) begin
            if (ngot < 400) got[ngot] = tx;
            ngot++;
            if (!tick_seen) stray++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    function automatic bit [15:0] ref_crc(input int m, input bit wide);
        bit [15:0] c;
        bit fb;
        c = 16'hFFFF;
        for (int i = 0; i < m; i++) begin
            if (wide) begin
                fb = data[i] ^ c[15];
                c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end else begin
                fb     = data[i] ^ c[7];
                c[7:0] = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        end
        return c;
    endfunction

    function automatic void build_exp(input int m, input bit ce, input bit cl);
        bit [15:0] c;
        int len;
        nexp = 0;
        if (m == 0) return;
        for (int k = 0; k < 8; k++) begin
            expb[nexp] = data[0] ^ k[0];
            nexp++;
        end
        for (int i = 0; i < m; i++) begin
            expb[nexp] = data[i];
            nexp++;
        end
        if (ce) begin
            len = cl ? 16 : 8;
            c   = ref_crc(m, cl);
            for (int j = len - 1; j >= 0; j--) begin
                expb[nexp] = c[j];
                nexp++;
            end
        end
    endfunction

    task automatic send_bit(input bit b);
        @(negedge clk);
        hdat = b; hck = 1'b1;
        @(negedge clk);
        @(negedge clk);
        hck = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_pkt(input int n, input bit ce, input bit cl,
                           input bit poke, input bit flip, input string tag);
        int lim, m, bad, guard;
        lim = MAXB - (ce ? (cl ? 16 : 8) : 0);
        m   = (n < lim) ? n : lim;
        @(negedge clk);
        cen = ce; clong = cl; en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(ovf == 1'b0, "R9", "overflow flag cleared at load start", ovf, 0);
        for (int i = 0; i < n; i++) send_bit(data[i]);
        ngot = 0;
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(busy == (m > 0), "R3", "busy one cycle after enable falls", busy, m > 0);
        if (flip) begin
            cen = ~ce; clong = ~cl;
        end
        if (poke)
            for (int i = 0; i < 5; i++) send_bit(1'($urandom));
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (6) @(negedge clk);
        cen = ce; clong = cl;
        build_exp(m, ce, cl);
        chk(ngot == nexp, tag, "line bit count", ngot, nexp);
        bad = -1;
        for (int i = 0; i < nexp && i < ngot; i++)
            if (bad < 0 && got[i] != expb[i]) bad = i;
        if (bad < 0) chk(1'b1, tag, "line bits", 0, 0);
        else chk(1'b0, tag, $sformatf("line bit %0d", bad), got[bad], expb[bad]);
        chk(ovf == (n > lim), "R9", "overflow flag after load", ovf, n > lim);
    endtask

    task automatic fill_random(input int n);
        for (int i = 0; i < n; i++) data[i] = 1'($urandom);
    endtask

    initial begin
        int n;
        bit ce, cl, pk;
        bit [7:0] by;
        bit [15:0] tail;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(ovf == 1'b0, "R1", "ovf in reset", ovf, 0);
        chk(stb == 1'b0, "R1", "strobe in reset", stb, 0);
        chk(tx == 1'b0, "R1", "tx in reset", tx, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 empty load starts nothing
        run_pkt(0, 1'b1, 1'b1, 1'b0, 1'b0, "R3");

        // R4 preamble phase for both first-bit values
        data[0] = 1'b0;
        run_pkt(1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        data[0] = 1'b1;
        run_pkt(1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");

        // R7 known message "123456789" gives CRC-16 0x29B1
        for (int b = 0; b < 9; b++) begin
            by = 8'h31 + 8'(b);
            for (int j = 0; j < 8; j++) data[8*b + j] = by[7 - j];
        end
        run_pkt(72, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        tail = '0;
        for (int i = 0; i < 16; i++)
            if (ngot - 16 + i >= 0 && ngot - 16 + i < 400) tail[15 - i] = got[ngot - 16 + i];
        chk(tail == 16'h29B1, "R7", "CRC-16 of known message", tail, 16'h29B1);

        // R8 same message with 8-bit CRC
        run_pkt(72, 1'b1, 1'b0, 1'b0, 1'b0, "R8");

        // R9 three bits past the 240-bit limit
        fill_random(243);
        run_pkt(243, 1'b1, 1'b1, 1'b0, 1'b0, "R9");

        // R11 configuration flipped right after the burst starts
        fill_random(20);
        run_pkt(20, 1'b1, 1'b0, 1'b0, 1'b1, "R11");

        // R2 full buffer without CRC
        fill_random(256);
        run_pkt(256, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

        // R10 host edges during the burst
        fill_random(30);
        run_pkt(30, 1'b1, 1'b0, 1'b1, 1'b0, "R10");

        // R5 random packets
        for (int t = 0; t < 25; t++) begin
            n  = 1 + int'($urandom % 260);
            ce = 1'($urandom);
            cl = 1'($urandom);
            pk = 1'($urandom);
            fill_random(n);
            run_pkt(n, ce, cl, pk, 1'b0, "R5");
        end

        chk(stray == 0, "R6", "strobes without a preceding tick", stray, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule